// File: doc/BRIEF.md
# Three-Source Interrupt Collector

This block collects interrupt events from three places: a one-clock "conversion finished" pulse from an analog-to-digital converter, a one-clock "transform finished" pulse from a vector arithmetic unit, and level changes on six general-purpose pins. Each source has its own enable. An enabled event sets sticky flags in a status word. The host reads that word through a small register port, and the read clears the flags. The block also produces a pull-down enable for an active-low, open-drain interrupt line, so several devices can share one wired line with an external pull-up.

Two control words configure the block. The system word holds the two converter/transform enables and the line mode. In pulse mode the line is pulled for one clock per event. In level mode it is pulled from the event until the status word is read. The pin word holds one change enable per pin. Pins whose direction input marks them as outputs never raise an event. The usual flow is: select the mode, enable the sources, wait for the line to fall, then read the status word to learn whether this device signalled and which source caused it.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, all enables are 0, pulse mode is selected, the status word reads 0 and `irq_pull` is 0.
- R2: Address 0 is the system word: bit 6 enables transform events, bit 7 enables converter events, and bit 8 selects level mode (1) or pulse mode (0). Address 1 is the pin word: bit 6+i enables change events for pin i, for i = 0..5. A read returns the stored bits and 0 in every other position. Address 3 reads 0.
- R3: `adc_done` high at a clock edge while the converter enable is 1 sets status bit 0 and summary bit 11 at that edge. With the enable at 0, the pulse has no effect.
- R4: `xform_done` high at a clock edge while the transform enable is 1 sets status bit 1 and summary bit 11 at that edge.
- R5: A rising or falling change on pin i, where `pio_is_out[i]`=0 and the pin enable is 1, sets status bit 2 and bit 11. The flags appear at the second clock edge after the first edge that samples the new pin value. A change on a pin marked as an output, or on a pin whose enable is 0, sets nothing.
- R6: Address 2 reads the status word: bit 0 converter, bit 1 transform, bit 2 pin change, bit 11 summary, all other bits 0. A read (`bus_rd` high at an edge with address 2) returns the current flags, and those flags are clear from that edge on. Writes to address 2 have no effect.
- R7: In pulse mode, each clock edge that accepts at least one enabled event raises `irq_pull` for exactly the following clock cycle.
- R8: In level mode, an enabled event raises `irq_pull` from the next cycle and holds it until a status read. The line is released in the cycle after the read edge and rises again only on a later enabled event.
- R9: An enabled event accepted at the same edge as a status read is not lost. Its flags and the level-mode line are set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 system, 1 pin, 2 status |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe; a status read clears the flags at the edge |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data for the current address (combinational) |
| adc_done | input | 1 | Converter end-of-conversion pulse |
| xform_done | input | 1 | Vector transform completion pulse |
| pio_pin | input | 6 | General-purpose pin levels (asynchronous) |
| pio_is_out | input | 6 | Per-pin direction, 1 = output |
| irq_pull | output | 1 | 1 = pull the shared active-low interrupt line low |

## Verification
The assertions assume that `adc_done`, `xform_done` and the bus strobes change only between clock edges, and that the pin inputs may change at any time because they pass through the synchronizer first. The hold property for level mode assumes that the mode bit stays the same, so it is waived in any cycle that writes the system word. The bench drives every input just after the falling clock edge. It mixes random writes, reads and source pulses in the same cycle, including a read that coincides with an event, which is the case the set-over-clear property covers.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W = 12;
    localparam int ADDR_W = 2;
    localparam int PIO_N  = 6;

    localparam logic [ADDR_W-1:0] A_SYS = 2'd0;
    localparam logic [ADDR_W-1:0] A_PIO = 2'd1;
    localparam logic [ADDR_W-1:0] A_STS = 2'd2;

    localparam int B_VTX_EN = 6;
    localparam int B_ADC_EN = 7;
    localparam int B_LEVEL  = 8;
    localparam int B_PIO_LO = 6;
    localparam int B_S_ADC  = 0;
    localparam int B_S_VTX  = 1;
    localparam int B_S_IO   = 2;
    localparam int B_S_SUM  = 11;

    typedef struct packed {
        logic level_mode;
        logic adc_en;
        logic vtx_en;
    } ctl_t;

    typedef struct packed {
        logic sum;
        logic io;
        logic vtx;
        logic adc;
    } sts_t;

    function automatic logic [DATA_W-1:0] sts_word(sts_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_S_ADC] = s.adc;
        w[B_S_VTX] = s.vtx;
        w[B_S_IO]  = s.io;
        w[B_S_SUM] = s.sum;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_word(ctl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_VTX_EN] = c.vtx_en;
        w[B_ADC_EN] = c.adc_en;
        w[B_LEVEL]  = c.level_mode;
        return w;
    endfunction

    function automatic ctl_t ctl_from_word(logic [DATA_W-1:0] w);
        ctl_t c;
        c.vtx_en     = w[B_VTX_EN];
        c.adc_en     = w[B_ADC_EN];
        c.level_mode = w[B_LEVEL];
        return c;
    endfunction
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_agg_pkg::*;
#(
    parameter int PIO = PIO_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl,
    output logic [PIO-1:0]    pio_en
);
    logic unused_lo;
    assign unused_lo = ^wdata[B_VTX_EN-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            pio_en <= '0;
        end else if (wr) begin
            if (addr == A_SYS) ctl <= ctl_from_word(wdata);
            if (addr == A_PIO) pio_en <= wdata[B_PIO_LO +: PIO];
        end
    end
endmodule

// File: rtl/irq_pin_watch.sv
module irq_pin_watch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] is_out,
    input  logic [N-1:0] en,
    output logic         fire
);
    logic [N-1:0] sync1, sync2, prev, chg;

    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                sync1[gi] <= 1'b0;
                sync2[gi] <= 1'b0;
                prev[gi]  <= 1'b0;
            end else begin
                sync1[gi] <= pin[gi];
                sync2[gi] <= sync1[gi];
                prev[gi]  <= sync2[gi];
            end
        end
        assign chg[gi] = (sync2[gi] ^ prev[gi]) & ~is_out[gi] & en[gi];
    end

    assign fire = |chg;
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adc_done,
    input  logic xform_done,
    input  logic io_fire,
    input  logic rd_clr,
    input  ctl_t ctl,
    output sts_t sts,
    output logic irq_pull
);
    logic fire_adc, fire_vtx, fire_any;
    logic hold_q, hold_nxt, pulse_q;
    sts_t sts_nxt;

    always_comb begin
        fire_adc = adc_done & ctl.adc_en;
        fire_vtx = xform_done & ctl.vtx_en;
        fire_any = fire_adc | fire_vtx | io_fire;
        // clear first, then set: an event at the read edge survives
        sts_nxt     = rd_clr ? '0 : sts;
        sts_nxt.adc = sts_nxt.adc | fire_adc;
        sts_nxt.vtx = sts_nxt.vtx | fire_vtx;
        sts_nxt.io  = sts_nxt.io  | io_fire;
        sts_nxt.sum = sts_nxt.sum | fire_any;
        hold_nxt    = (rd_clr ? 1'b0 : hold_q) | fire_any;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts     <= '0;
            hold_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            sts     <= sts_nxt;
            hold_q  <= hold_nxt;
            pulse_q <= fire_any;
        end
    end

    assign irq_pull = ctl.level_mode ? hold_q : pulse_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              adc_done,
    input  logic              xform_done,
    input  logic [PIO_N-1:0]  pio_pin,
    input  logic [PIO_N-1:0]  pio_is_out,
    output logic              irq_pull
);
    ctl_t             ctl;
    sts_t             sts;
    logic [PIO_N-1:0] pio_en;
    logic             io_fire;
    logic             rd_clr;

    assign rd_clr = bus_rd && (bus_addr == A_STS);

    irq_ctl_regs #(.PIO(PIO_N)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .ctl(ctl), .pio_en(pio_en)
    );

    irq_pin_watch #(.N(PIO_N)) u_pins (
        .clk(clk), .rst(rst), .pin(pio_pin), .is_out(pio_is_out),
        .en(pio_en), .fire(io_fire)
    );

    irq_status_core u_core (
        .clk(clk), .rst(rst), .adc_done(adc_done), .xform_done(xform_done),
        .io_fire(io_fire), .rd_clr(rd_clr), .ctl(ctl), .sts(sts),
        .irq_pull(irq_pull)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_SYS:   bus_rdata = ctl_word(ctl);
            A_PIO:   bus_rdata[B_PIO_LO +: PIO_N] = pio_en;
            A_STS:   bus_rdata = sts_word(sts);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              adc_done,
    input logic              xform_done,
    input ctl_t              ctl,
    input sts_t              sts,
    input logic              io_fire,
    input logic              irq_pull
);
    logic unused_rd;
    assign unused_rd = ^{bus_rdata[DATA_W-1], bus_rdata[2:0]};

    // R3
    adc_set_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_done && ctl.adc_en) |=> (sts.adc && sts.sum));

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_STS && !(adc_done && ctl.adc_en)
         && !(xform_done && ctl.vtx_en) && !io_fire) |=> (sts == '0));

    // R6
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_STS) |-> (bus_rdata[DATA_W-2:3] == '0));

    // R9
    race_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_STS && adc_done && ctl.adc_en) |=> sts.adc);

    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.level_mode && irq_pull && !(bus_rd && bus_addr == A_STS)
         && !(bus_wr && bus_addr == A_SYS)) |=> irq_pull);

    // R7
    edge_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.level_mode && irq_pull) |->
        ($past(adc_done && ctl.adc_en) || $past(xform_done && ctl.vtx_en) || $past(io_fire)));

    // R1
    summary_chk: assert property (@(posedge clk) disable iff (rst)
        sts.sum == (sts.adc | sts.vtx | sts.io));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .adc_done(adc_done),
    .xform_done(xform_done), .ctl(ctl), .sts(sts), .io_fire(io_fire),
    .irq_pull(irq_pull)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_wdata = '0;
    logic [11:0] bus_rdata;
    logic        adc_done = 1'b0, xform_done = 1'b0;
    logic [5:0]  pio_pin = '0, pio_is_out = '0;
    logic        irq_pull;

    always #5 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .adc_done(adc_done), .xform_done(xform_done), .pio_pin(pio_pin),
        .pio_is_out(pio_is_out), .irq_pull(irq_pull)
    );

    int n_chk = 0, n_fail = 0;

    // stimulus for the next cycle
    logic        s_adc = 0, s_vtx = 0, s_rd = 0, s_wr = 0;
    logic [1:0]  s_addr = 0;
    logic [11:0] s_wdata = 0;
    logic [5:0]  s_pin = 0, s_dir = 0;
    logic [11:0] last_rd = 0;

    // reference model state
    logic [11:0] m_sys = 0;
    logic [5:0]  m_pen = 0;
    logic [3:0]  m_sts = 0;   // {sum, io, vtx, adc}
    logic        m_lvl = 0, m_pulse = 0;
    logic [5:0]  m_s1 = 0, m_s2 = 0, m_prev = 0;

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_sys & 12'h1C0;
            2'd1:    return {m_pen, 6'b0};
            2'd2:    return {m_sts[3], 8'b0, m_sts[2:0]};
            default: return 12'h000;
        endcase
    endfunction

    task automatic step();
        logic fa, fv, fi, fany, clr;
        @(negedge clk);
        adc_done = s_adc; xform_done = s_vtx; bus_rd = s_rd; bus_wr = s_wr;
        bus_addr = s_addr; bus_wdata = s_wdata; pio_pin = s_pin; pio_is_out = s_dir;
        #1;
        if (s_rd) begin
            last_rd = bus_rdata;
            chk(s_addr == 2'd2 ? "R6 status read" : "R2 register read", bus_rdata, exp_read(s_addr));
        end
        fa   = s_adc & m_sys[7];
        fv   = s_vtx & m_sys[6];
        fi   = |((m_s2 ^ m_prev) & ~s_dir & m_pen);
        fany = fa | fv | fi;
        clr  = s_rd && (s_addr == 2'd2);
        if (clr) m_sts = 4'b0;
        m_sts   = m_sts | {fany, fi, fv, fa};
        m_lvl   = (clr ? 1'b0 : m_lvl) | fany;
        m_pulse = fany;
        m_prev  = m_s2; m_s2 = m_s1; m_s1 = s_pin;
        if (s_wr && s_addr == 2'd0) m_sys = s_wdata;
        if (s_wr && s_addr == 2'd1) m_pen = s_wdata[11:6];
        @(posedge clk);
        #1;
        chk(m_sys[8] ? "R8 level irq" : "R7 pulse irq", {11'b0, irq_pull},
            {11'b0, m_sys[8] ? m_lvl : m_pulse});
    endtask

    task automatic quiet();
        s_adc = 0; s_vtx = 0; s_rd = 0; s_wr = 0;
    endtask
    task automatic idle(input int n);
        quiet();
        for (int i = 0; i < n; i++) step();
    endtask
    task automatic wr_reg(input logic [1:0] a, input logic [11:0] d);
        quiet(); s_wr = 1; s_addr = a; s_wdata = d; step(); quiet();
    endtask
    task automatic rd_reg(input logic [1:0] a);
        quiet(); s_rd = 1; s_addr = a; step(); quiet();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1 chk("R1 irq after reset", {11'b0, irq_pull}, 12'h000);
        rd_reg(2'd0); chk("R1 system word reset", last_rd, 12'h000);
        rd_reg(2'd1); chk("R1 pin word reset", last_rd, 12'h000);
        rd_reg(2'd2); chk("R1 status reset", last_rd, 12'h000);

        // R2 readback masks
        wr_reg(2'd0, 12'hFFF); rd_reg(2'd0); chk("R2 system readback", last_rd, 12'h1C0);
        wr_reg(2'd1, 12'hFFF); rd_reg(2'd1); chk("R2 pin readback", last_rd, 12'hFC0);
        rd_reg(2'd3); chk("R2 spare address", last_rd, 12'h000);
        wr_reg(2'd1, 12'h000);

        // R3 converter source, pulse mode (R7)
        wr_reg(2'd0, 12'h080);
        quiet(); s_adc = 1; step(); quiet();
        chk("R7 pulse high", {11'b0, irq_pull}, 12'h001);
        idle(1);
        chk("R7 pulse one clock", {11'b0, irq_pull}, 12'h000);
        rd_reg(2'd2); chk("R3 converter flag", last_rd, 12'h801);
        wr_reg(2'd0, 12'h000);
        quiet(); s_adc = 1; step(); quiet();
        rd_reg(2'd2); chk("R3 disabled converter ignored", last_rd, 12'h000);

        // R4 transform source
        wr_reg(2'd0, 12'h040);
        quiet(); s_vtx = 1; step(); quiet(); idle(1);
        rd_reg(2'd2); chk("R4 transform flag", last_rd, 12'h802);

        // R5 pin changes
        wr_reg(2'd1, 12'h040); s_dir = 6'h00; s_pin[0] = 1'b1; idle(4);
        rd_reg(2'd2); chk("R5 rising change", last_rd, 12'h804);
        s_dir = 6'h01; s_pin[0] = 1'b0; idle(4);
        rd_reg(2'd2); chk("R5 output pin ignored", last_rd, 12'h000);
        s_dir = 6'h00; wr_reg(2'd1, 12'h000); s_pin[0] = 1'b1; idle(4);
        rd_reg(2'd2); chk("R5 disabled pin ignored", last_rd, 12'h000);
        wr_reg(2'd1, 12'h040); s_pin[0] = 1'b0; idle(4);
        rd_reg(2'd2); chk("R5 falling change", last_rd, 12'h804);

        // R6 write ignored, clear on read
        wr_reg(2'd2, 12'hFFF); rd_reg(2'd2); chk("R6 status write ignored", last_rd, 12'h000);
        wr_reg(2'd0, 12'h080);
        quiet(); s_adc = 1; step(); quiet();
        rd_reg(2'd2); chk("R6 first read", last_rd, 12'h801);
        rd_reg(2'd2); chk("R6 second read cleared", last_rd, 12'h000);

        // R8 level mode
        wr_reg(2'd0, 12'h180);
        quiet(); s_adc = 1; step(); quiet(); idle(3);
        chk("R8 line held", {11'b0, irq_pull}, 12'h001);
        rd_reg(2'd2);
        chk("R8 released after read", {11'b0, irq_pull}, 12'h000);

        // R9 event coincident with read
        quiet(); s_adc = 1; s_rd = 1; s_addr = 2'd2; step(); quiet();
        chk("R9 read before event", last_rd, 12'h000);
        chk("R9 line set", {11'b0, irq_pull}, 12'h001);
        rd_reg(2'd2); chk("R9 event kept", last_rd, 12'h801);

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            s_adc = ($urandom % 5) == 0;
            s_vtx = ($urandom % 5) == 0;
            s_rd  = ($urandom % 4) == 0;
            s_wr  = ($urandom % 20) == 0;
            s_addr = s_rd ? (($urandom % 3) == 0 ? 2'($urandom % 4) : 2'd2) : 2'($urandom % 3);
            s_wdata = 12'($urandom);
            if (($urandom % 3) == 0) s_pin[$urandom % 6] ^= 1'b1;
            if (($urandom % 40) == 0) s_dir = 6'($urandom);
            step();
        end
        quiet(); idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule